// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. A host reaches it over a simple 32-bit register bus: a word index on the address, a write strobe with write data, and a read strobe whose data returns on the next clock. For each pin the host sets the direction and the output level, and reads back the current pin state. Input pins pass through a two-flop synchroniser before any use.

Each pin can also be a source of interrupts. It can trigger on a level, high or low, or on one edge, rising or falling. The raw trigger condition of every pin is visible in a status register. The controller latches that condition until the host clears it, masks it with the pin's enable bit, and ORs all the pending bits into one interrupt line to the host. The usual service routine reads the pending register, writes the same value to the clear register, and then handles each reported pin.

Word addresses, given as byte offsets: value 0x00, direction 0x04, enable 0x08, status 0x0C, pending 0x10, clear 0x14, trigger select 0x18, polarity 0x1C. Address bits [1:0] are ignored.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable, select, polarity and output registers are 0 and every direction bit is 1. `irq_out` is 0, `pin_oe` is all 0 and `bus_rdata` is 0.
- R2: A direction bit of 1 makes its pin an input, so `pin_oe` for that pin is 0. A direction bit of 0 makes the pin an output, so `pin_oe` is 1 and `pin_out` carries the output register bit. `pin_oe` changes only on a write to 0x04.
- R3: A read of 0x00 returns the output register bit for output pins and the synchronised input for input pins. A write to 0x00 stores all bits, including those of input pins, and `pin_out` changes only on such a write.
- R4: With select bit 0 (level mode), polarity 1 makes the pin active while its input is high, and polarity 0 makes it active while the input is low.
- R5: With select bit 1 (edge mode), polarity 0 detects a rising edge and polarity 1 detects a falling edge. The latched event stays after the input returns to its old level.
- R6: Writing 1 to a bit of 0x14 clears that pin's latched event, and bits written as 0 have no effect. If a new event and a clear meet in the same cycle, the event wins. A read of 0x14 returns 0.
- R7: The status register at 0x0C shows each pin's raw trigger condition whatever its enable bit.
- R8: Pending (0x10) is the latched event ANDed with the enable bit, and `irq_out` is the OR of the pending bits. Writing 0 to 0x08 masks every pin, so `irq_out` is 0 after that write.
- R9: Read-data bits at and above `NPINS` are 0. Writes to the status and pending registers are ignored.
- R10: When an input changes at a point between clock edges, the third rising edge after that point is the first one at which the pending bit can be set and `irq_out` can rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; data returns on the next clock |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables, 1 = drive |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a new edge. The edge exists only for one cycle, two clocks after the input moves. The bench counts clock edges from the input change and places the clear write so that the write commits on the edge where the event latches, and then expects the pending bit to survive. Random pin values, directions and trigger modes are also checked against a model of the status and value registers, and each result is read only after the synchroniser has settled.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO controller.
// Assumes word-aligned byte addressing: bits [4:2] select one of eight words.
package gpio_pkg;
    localparam int IDX_LSB = 2;
    localparam int IDX_W   = 3;

    typedef enum logic [IDX_W-1:0] {
        REG_VAL  = 3'd0,
        REG_DIR  = 3'd1,
        REG_EN   = 3'd2,
        REG_STAT = 3'd3,
        REG_PEND = 3'd4,
        REG_CLR  = 3'd5,
        REG_SEL  = 3'd6,
        REG_POL  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage input synchroniser with a one-cycle history stage.
// Assumes pin_in is asynchronous. q is the settled value and q_prev is q
// one clock earlier, which the edge detector uses.
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] stg [STAGES+1];

    // First stage captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s <= STAGES; s++) begin : g_stage
            // Shift the sample one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q      = stg[STAGES-1];
    assign q_prev = stg[STAGES];
endmodule

// File: rtl/gpio_trig.sv
// Per-pin trigger evaluation, purely combinational.
// Level mode (sel=0): pol=1 active high, pol=0 active low.
// Edge mode (sel=1): pol=0 rising, pol=1 falling.
module gpio_trig #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic rise, fall, lvl_act, edge_act;
            // Decode both modes and pick the one the select bit names.
            always_comb begin
                rise     = cur[i] & ~prev[i];
                fall     = ~cur[i] & prev[i];
                lvl_act  = pol[i] ? cur[i] : ~cur[i];
                edge_act = pol[i] ? fall : rise;
                hit[i]   = sel[i] ? edge_act : lvl_act;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
// Register file, event latch and read path of the GPIO controller.
// Assumes one access per cycle; a read returns on the next clock.
// The event latch is W1C through the clear word, and a set wins over a clear.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_sync,
    input  logic [NPINS-1:0]  trig_raw,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  outv_q,
    output logic [NPINS-1:0]  sel_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  pend,
    output logic              irq
);
    reg_idx_e         idx;
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] evt_q;
    logic [NPINS-1:0] wpins;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] rd_pins;
    logic [31:0]      rd_word;

    assign idx   = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
    assign wpins = bus_wdata[NPINS-1:0];

    // Control registers, each written whole from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            outv_q <= '0;
            en_q   <= '0;
            sel_q  <= '0;
            pol_q  <= '0;
        end else if (bus_we) begin
            case (idx)
                REG_VAL: outv_q <= wpins;
                REG_DIR: dir_q  <= wpins;
                REG_EN:  en_q   <= wpins;
                REG_SEL: sel_q  <= wpins;
                REG_POL: pol_q  <= wpins;
                default: ;
            endcase
        end
    end

    // Ones written to the clear word form a one-cycle clear mask.
    always_comb begin
        clr_mask = '0;
        if (bus_we && idx == REG_CLR) clr_mask = wpins;
    end

    // Event latch: a new trigger sets, a clear resets, and the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= trig_raw | (evt_q & ~clr_mask);
    end

    assign pend = evt_q & en_q;
    assign irq  = |pend;

    // Select the pin-wide read value.
    always_comb begin
        case (idx)
            REG_VAL:  rd_pins = (dir_q & pin_sync) | (~dir_q & outv_q);
            REG_DIR:  rd_pins = dir_q;
            REG_EN:   rd_pins = en_q;
            REG_STAT: rd_pins = trig_raw;
            REG_PEND: rd_pins = pend;
            REG_SEL:  rd_pins = sel_q;
            REG_POL:  rd_pins = pol_q;
            default:  rd_pins = '0;
        endcase
        rd_word = 32'(rd_pins);
    end

    // Register the read data when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the GPIO controller: synchroniser, trigger logic and register file.
// Assumes NPINS is between 1 and 32 and ADDR_W is at least 5.
module gpio_irq_ctrl #(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_out
);
    logic [NPINS-1:0] s_cur, s_prev, raw;
    logic [NPINS-1:0] dir, outv, sel, pol, pend;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (s_cur),
        .q_prev (s_prev)
    );

    gpio_trig #(.W(NPINS)) u_trig (
        .cur  (s_cur),
        .prev (s_prev),
        .sel  (sel),
        .pol  (pol),
        .hit  (raw)
    );

    gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pin_sync  (s_cur),
        .trig_raw  (raw),
        .dir_q     (dir),
        .outv_q    (outv),
        .sel_q     (sel),
        .pol_q     (pol),
        .pend      (pend),
        .irq       (irq_out)
    );

    // A direction bit of 1 means input, so the pin is driven when the bit is 0.
    assign pin_oe  = ~dir;
    assign pin_out = outv;
endmodule

// File: rtl/gpio_irq_chk.sv
// Port-level checker for gpio_irq_ctrl, attached by bind.
module gpio_irq_chk
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq_out
);
    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[IDX_LSB +: IDX_W];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && pin_oe == '0 && bus_rdata == '0)); // R1

    AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && idx == REG_DIR) |=> $stable(pin_oe)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && idx == REG_VAL) |=> $stable(pin_out)); // R3

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(bus_we && (idx == REG_CLR || idx == REG_EN))); // R8

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && idx == REG_CLR) |=> bus_rdata == '0); // R6

    generate
        if (NPINS < 32) begin : g_upper
            AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[31:NPINS] == '0); // R9
        end
    endgenerate
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
    localparam int NP = 24;
    localparam logic [31:0] M = (32'h1 << NP) - 1;
    localparam logic [4:0] A_VAL = 5'h00, A_DIR = 5'h04, A_EN = 5'h08, A_STAT = 5'h0C,
                           A_PEND = 5'h10, A_CLR = 5'h14, A_SEL = 5'h18, A_POL = 5'h1C;

    logic clk = 0, rst_n = 0;
    logic [4:0] bus_addr = '0;
    logic bus_we = 0, bus_re = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
    logic irq_out;
    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1;
        @(negedge clk);
        bus_re = 0; d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_stat(logic [31:0] in, logic [31:0] sel, logic [31:0] pol);
        return (~sel & ((pol & in) | (~pol & ~in))) & M;
    endfunction

    function automatic logic [31:0] exp_val(logic [31:0] in, logic [31:0] dir, logic [31:0] ov);
        return ((dir & in) | (~dir & ov)) & M;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk("R1 irq after reset", {31'd0, irq_out}, 0);
        chk("R1 oe after reset", 32'(pin_oe), 0);
        chk("R1 rdata after reset", bus_rdata, 0);
        rst_n = 1;
        rd(A_DIR, d);  chk("R1 dir reset", d, M);
        rd(A_EN, d);   chk("R1 en reset", d, 0);
        rd(A_SEL, d);  chk("R1 sel reset", d, 0);

        // R2 / R3 direction and value
        wr(A_VAL, 32'h00A5_5A3C);
        wr(A_DIR, 32'hFFFF_FF0F);
        chk("R2 oe", 32'(pin_oe), 32'h0000_00F0);
        chk("R3 pin_out", 32'(pin_out), 32'h00A5_5A3C);
        pin_in = 24'h0F0F00;
        settle();
        rd(A_VAL, d); chk("R3 value mixed", d, exp_val(32'h0F0F00, 32'hFFFF0F, 32'hA55A3C));
        rd(A_CLR, d); chk("R6 clear reads zero", d, 0);
        rd(A_VAL, d); chk("R9 upper bits zero", d & ~M, 0);

        // Random trigger and value patterns
        for (int k = 0; k < 40; k++) begin
            logic [31:0] rin, rsel, rpol, rdir, rov;
            rin = $urandom & M; rsel = $urandom & M; rpol = $urandom & M;
            rdir = $urandom & M; rov = $urandom & M;
            if (k == 0) begin rsel = 0; rpol = M; end
            if (k == 1) begin rsel = 0; rpol = 0; end
            wr(A_SEL, rsel); wr(A_POL, rpol); wr(A_DIR, rdir); wr(A_VAL, rov);
            pin_in = rin[NP-1:0];
            settle();
            rd(A_STAT, d); chk("R4 R7 status random", d, exp_stat(rin, rsel, rpol));
            rd(A_VAL, d);  chk("R3 value random", d, exp_val(rin, rdir, rov));
        end

        // Edge setup: all pins edge mode rising, inputs low, all inputs
        wr(A_DIR, M); wr(A_SEL, M); wr(A_POL, 0); wr(A_EN, 0);
        pin_in = '0; settle();
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_PEND, d); chk("R8 pending zero after clear", d, 0);
        wr(A_EN, 32'h0000_0028);

        // R10 / R5 rising edge on pin 3 and its latency
        @(negedge clk); pin_in[3] = 1;
        @(negedge clk); chk("R10 irq after 1 edge", {31'd0, irq_out}, 0);
        @(negedge clk); chk("R10 irq after 2 edges", {31'd0, irq_out}, 0);
        @(negedge clk); chk("R10 irq after 3 edges", {31'd0, irq_out}, 1);
        pin_in[3] = 0; settle();
        rd(A_PEND, d); chk("R5 rising latched", d, 32'h8);

        // R6 zeros have no effect, ones clear
        wr(A_CLR, 32'hFFFF_FFF7);
        rd(A_PEND, d); chk("R6 zero bit keeps pending", d, 32'h8);
        wr(A_CLR, 32'h8);
        chk("R6 one bit clears", {31'd0, irq_out}, 0);

        // R5 falling edge on pin 5 with polarity 1; a rising edge must not trigger
        wr(A_POL, 32'h20);
        pin_in[5] = 1; settle();
        rd(A_PEND, d); chk("R5 rise ignored with pol1", d, 0);
        pin_in[5] = 0; settle();
        rd(A_PEND, d); chk("R5 falling latched", d, 32'h20);
        wr(A_CLR, 32'h20);

        // R6 set wins: the clear commits on the same edge where the event latches
        @(negedge clk); pin_in[3] = 1;
        @(negedge clk);
        @(negedge clk); bus_addr = A_CLR; bus_wdata = 32'h8; bus_we = 1;
        @(negedge clk); bus_we = 0;
        chk("R6 set wins over clear", {31'd0, irq_out}, 1);
        pin_in[3] = 0; settle();
        wr(A_CLR, 32'hFFFF_FFFF);

        // R9 writes to status and pending are ignored
        pin_in[3] = 1; settle();
        wr(A_PEND, 0); wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_PEND, d); chk("R9 pending write ignored", d, 32'h8);
        rd(A_STAT, d); chk("R9 status write ignored", d, 0);

        // R8 global mask through enable
        wr(A_EN, 0);
        chk("R8 masked irq", {31'd0, irq_out}, 0);
        rd(A_PEND, d); chk("R8 masked pending", d, 0);
        wr(A_EN, 32'h8);
        chk("R8 unmask irq", {31'd0, irq_out}, 1);
        wr(A_CLR, 32'hFFFF_FFFF); wr(A_EN, 0);

        // R4 / R7 level mode on pin 7, active high, enable off
        wr(A_SEL, 0); wr(A_POL, 32'h80);
        pin_in = 24'h000080; settle();
        rd(A_STAT, d); chk("R7 status ignores enable", d & 32'h80, 32'h80);
        wr(A_CLR, 32'h80);
        wr(A_EN, 32'h80);
        chk("R4 level high irq", {31'd0, irq_out}, 1);
        wr(A_CLR, 32'h80);
        chk("R4 level stays while active", {31'd0, irq_out}, 1);
        pin_in[7] = 0; settle();
        wr(A_CLR, 32'h80);
        chk("R4 level cleared when inactive", {31'd0, irq_out}, 0);
        wr(A_POL, 0); settle();
        chk("R4 level low irq", {31'd0, irq_out}, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule